// File: doc/BRIEF.md
# Byte Permute Selection Unit

The unit builds one 32-bit result from a 64-bit source. The source is two 32-bit data operands placed side by side. A third 32-bit operand, the selector word, carries one 8-bit code for each result byte. Each code does one of four things. It copies any of the eight source bytes. It fills the byte with the sign bit of one of the four 16-bit halves of the source. It forces 0x00. It forces 0xFF.

The four lanes decode their codes independently, so any mix of codes in one selector word is legal. In the default registered form, the operands are sampled on a clock edge where `in_valid` is high. The result and `out_valid` appear one clock later. A parameter selects a purely combinational form instead, for use inside a larger pipeline stage.

Top module: `bps_byte_permute`

## Requirements
- R1: The 64-bit source is `{hi_word, lo_word}`. Source byte k (k = 0..7) is source bits [8k+7:8k], so bytes 0..3 come from `lo_word` and bytes 4..7 come from `hi_word`.
- R2: Result byte i (i = 0..3, bits [8i+7:8i]) is controlled only by selector bits [8i+7:8i]. The lanes are independent, so any combination of codes across the four lanes gives each lane its own rule.
- R3: Codes 0 to 7 copy source byte number `code` into the result byte.
- R4: Codes 8 to 11 fill the result byte with eight copies of a single source bit. That bit is 15, 31, 47 or 63 for code 8, 9, 10 or 11, which is the top bit of source half (code−8). The byte is therefore 0x00 or 0xFF.
- R5: Code 12 makes the result byte 0x00.
- R6: Every code from 13 to 255 makes the result byte 0xFF. All 8 bits of the code are decoded, and no value wraps onto a lower code.
- R7: In the registered form, a transfer sampled with `in_valid` high on a rising edge drives `out_valid` high and `result` to its value immediately after that same edge.
- R8: A rising edge with `in_valid` low drives `out_valid` low. It also leaves `result` unchanged, even when the data and selector inputs change.
- R9: A rising edge with `rst_n` low clears `out_valid` and `result` to zero, whatever `in_valid` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands are valid this cycle |
| hi_word | input | 32 | Upper half of the 64-bit source |
| lo_word | input | 32 | Lower half of the 64-bit source |
| sel_word | input | 32 | Four 8-bit selector codes, one per result byte |
| out_valid | output | 1 | Result is valid |
| result | output | 32 | Permuted result |

## Verification
Every result is due one rising edge after the operands are sampled. The bench drives its inputs on the falling edge and samples `result` and `out_valid` on the next falling edge, so each comparison sits half a period after the edge that produced it. The same timing applies to the hold check and the reset checks: the bench changes the inputs with `in_valid` low, or pulls reset, and reads the ports one edge later. The directed sweep walks all 256 codes through each lane while the other lanes carry random codes. Random operands and mixed selector words then follow.

// File: rtl/bps_pkg.sv
// Package: types shared by the byte permute unit.
// Assumes: one selector code per result byte, decoded into one of four kinds.
package bps_pkg;

    // What a selector code asks its lane to produce
    typedef enum logic [1:0] {
        SK_BYTE = 2'd0,   // copy one source byte
        SK_SIGN = 2'd1,   // replicate the top bit of one source half
        SK_ZERO = 2'd2,   // constant 0x00
        SK_ONES = 2'd3    // constant all ones
    } sel_kind_e;

endpackage

// File: rtl/bps_sel_decode.sv
// Module: bps_sel_decode
// Turns one full-width selector code into a kind and a small index.
// Assumes: LANES is a power of two. The sign codes therefore start at
// 2*LANES, which has its low IDX_W bits clear, so the low code bits give
// the index directly for both the byte kind and the sign kind.
module bps_sel_decode
    import bps_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter int IDX_W  = $clog2(2 * LANES)
) (
    input  logic [LANE_W-1:0] code,
    output sel_kind_e         kind,
    output logic [IDX_W-1:0]  idx
);

    localparam int NSRC  = 2 * LANES;
    localparam int NHALF = LANES;
    localparam logic [LANE_W-1:0] SIGN_BASE = LANE_W'(NSRC);
    localparam logic [LANE_W-1:0] ZERO_CODE = LANE_W'(NSRC + NHALF);

    // Classify the whole code; no bits are masked before the compares
    always_comb begin
        idx = code[IDX_W-1:0];
        if (code < SIGN_BASE)
            kind = SK_BYTE;
        else if (code < ZERO_CODE)
            kind = SK_SIGN;
        else if (code == ZERO_CODE)
            kind = SK_ZERO;
        else
            kind = SK_ONES;
    end

    // R6: a code above the zero code always decodes as all ones
    always_comb begin
        if (code > ZERO_CODE)
            a_r6_high_codes: assert (kind == SK_ONES);
    end

endmodule

// File: rtl/bps_lane.sv
// Module: bps_lane
// Builds one result byte from the 64-bit source and a decoded selector.
// Assumes: idx is below 2*LANES for the byte kind and below LANES for
// the sign kind, which the decoder guarantees.
module bps_lane
    import bps_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter int IDX_W  = $clog2(2 * LANES)
) (
    input  logic [2*LANES*LANE_W-1:0] src,
    input  sel_kind_e                 kind,
    input  logic [IDX_W-1:0]          idx,
    output logic [LANE_W-1:0]         lane_out
);

    localparam int NSRC   = 2 * LANES;
    localparam int NHALF  = LANES;
    localparam int HALF_W = 2 * LANE_W;
    localparam int HIDX_W = (NHALF > 1) ? $clog2(NHALF) : 1;

    logic [LANE_W-1:0] src_bytes [NSRC];
    logic [NHALF-1:0]  half_msb;
    logic              sign_bit;

    // Split the source into bytes and gather the top bit of each half
    for (genvar k = 0; k < NSRC; k++) begin : g_bytes
        assign src_bytes[k] = src[k*LANE_W +: LANE_W];
    end
    for (genvar h = 0; h < NHALF; h++) begin : g_halves
        assign half_msb[h] = src[h*HALF_W + HALF_W - 1];
    end

    // Pick the sign bit of the half named by the low index bits
    assign sign_bit = half_msb[idx[HIDX_W-1:0]];

    // Choose the byte the decoded kind asks for
    always_comb begin
        unique case (kind)
            SK_BYTE: lane_out = src_bytes[idx];
            SK_SIGN: lane_out = {LANE_W{sign_bit}};
            SK_ZERO: lane_out = '0;
            default: lane_out = '1;
        endcase
    end

    // R4: a sign fill is always a uniform byte
    always_comb begin
        if (kind == SK_SIGN)
            a_r4_uniform_fill: assert (lane_out == '0 || lane_out == '1);
    end

endmodule

// File: rtl/bps_out_stage.sv
// Module: bps_out_stage
// Holds the result and the valid flag, or passes them straight through.
// Assumes: synchronous active-low reset; the result loads only on valid.
module bps_out_stage #(
    parameter int DATA_W     = 32,
    parameter bit REGISTERED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] d,
    output logic              out_valid,
    output logic [DATA_W-1:0] q
);

    if (REGISTERED) begin : g_reg
        // Register the valid flag; reset clears it
        always_ff @(posedge clk) begin
            if (!rst_n) out_valid <= 1'b0;
            else        out_valid <= in_valid;
        end

        // Register the result on valid; hold it otherwise
        always_ff @(posedge clk) begin
            if (!rst_n)        q <= '0;
            else if (in_valid) q <= d;
        end

        // R7: a sampled transfer shows up one edge later
        a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (out_valid && q == $past(d)));

        // R8: an idle edge drops valid and keeps the result
        a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!in_valid && $past(rst_n)) |=> (!out_valid && $stable(q)));
    end else begin : g_comb
        // Pass the valid flag and the result straight through
        assign out_valid = in_valid;
        assign q         = d;
    end

endmodule

// File: rtl/bps_byte_permute.sv
// Module: bps_byte_permute (top)
// Builds a DATA_W result from {hi_word, lo_word} under per-byte selector codes.
// Assumes: DATA_W / LANE_W lanes, a power of two; REGISTERED picks a
// one-cycle registered output or a purely combinational one.
module bps_byte_permute
    import bps_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int LANE_W     = 8,
    parameter bit REGISTERED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] hi_word,
    input  logic [DATA_W-1:0] lo_word,
    input  logic [DATA_W-1:0] sel_word,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);

    localparam int LANES = DATA_W / LANE_W;
    localparam int SRC_W = 2 * DATA_W;
    localparam int IDX_W = $clog2(2 * LANES);

    logic [SRC_W-1:0]  src;
    logic [DATA_W-1:0] comb_result;

    // Place the first operand above the second to form the source
    assign src = {hi_word, lo_word};

    // One decoder and one byte builder for each result lane
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        sel_kind_e        kind;
        logic [IDX_W-1:0] idx;

        bps_sel_decode #(.LANES(LANES), .LANE_W(LANE_W), .IDX_W(IDX_W)) u_dec (
            .code (sel_word[i*LANE_W +: LANE_W]),
            .kind (kind),
            .idx  (idx)
        );

        bps_lane #(.LANES(LANES), .LANE_W(LANE_W), .IDX_W(IDX_W)) u_lane (
            .src      (src),
            .kind     (kind),
            .idx      (idx),
            .lane_out (comb_result[i*LANE_W +: LANE_W])
        );

        if (REGISTERED) begin : g_chk
            // R3: a byte code copies that source byte one edge later
            a_r3_byte_copy: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && sel_word[i*LANE_W +: LANE_W] < LANE_W'(2 * LANES))
                |=> result[i*LANE_W +: LANE_W] ==
                    $past(src[sel_word[i*LANE_W +: IDX_W]*LANE_W +: LANE_W]));

            // R5: the zero code gives 0x00
            a_r5_zero_code: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && sel_word[i*LANE_W +: LANE_W] == LANE_W'(3 * LANES))
                |=> result[i*LANE_W +: LANE_W] == '0);

            // R6: codes above the zero code give all ones
            a_r6_ones_code: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && sel_word[i*LANE_W +: LANE_W] > LANE_W'(3 * LANES))
                |=> result[i*LANE_W +: LANE_W] == '1);
        end
    end

    // Register or pass through the assembled result
    bps_out_stage #(.DATA_W(DATA_W), .REGISTERED(REGISTERED)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .d         (comb_result),
        .out_valid (out_valid),
        .q         (result)
    );

endmodule

// File: tb/sim_bps_byte_permute.sv
module sim_bps_byte_permute;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] hi_word, lo_word, sel_word;
    logic        out_valid;
    logic [31:0] result;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    bps_byte_permute u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .hi_word(hi_word), .lo_word(lo_word), .sel_word(sel_word),
        .out_valid(out_valid), .result(result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model of the selection rule
    function automatic logic [31:0] ref_perm(input logic [31:0] h, input logic [31:0] l,
                                             input logic [31:0] s);
        logic [63:0] w;
        logic [31:0] r;
        w = {h, l};
        r = '0;
        for (int i = 0; i < 4; i++) begin
            int c;
            logic [7:0] b;
            c = int'(s[i*8 +: 8]);
            if (c >= 13)      b = 8'hFF;
            else if (c == 12) b = 8'h00;
            else if (c >= 8)  b = w[(c - 8) * 16 + 15] ? 8'hFF : 8'h00;
            else              b = w[c*8 +: 8];
            r[i*8 +: 8] = b;
        end
        return r;
    endfunction

    // Requirement tag for a code in the sweep
    function automatic string tag_of(input int c);
        if (c < 8)       return "R3";
        else if (c < 12) return "R4";
        else if (c == 12) return "R5";
        else             return "R6";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Drive one valid transfer and check the result one edge later
    task automatic run_op(input string tag, input logic [31:0] h, input logic [31:0] l,
                          input logic [31:0] s);
        @(negedge clk);
        in_valid = 1'b1; hi_word = h; lo_word = l; sel_word = s;
        @(negedge clk);
        check({tag, " result"}, result, ref_perm(h, l, s));
        check("R7 valid", {31'd0, out_valid}, 32'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] last;
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; in_valid = 1'b0;
        hi_word = '0; lo_word = '0; sel_word = '0;
        repeat (3) @(negedge clk);
        check("R9 reset valid", {31'd0, out_valid}, 32'd0);
        check("R9 reset result", result, 32'd0);
        rst_n = 1'b1;

        // R1: byte placement of the two operands
        run_op("R1", 32'h8877_6655, 32'h4433_2211, 32'h0706_0504);
        run_op("R1", 32'h8877_6655, 32'h4433_2211, 32'h0302_0100);
        // R4: each half's sign bit, both polarities
        run_op("R4", 32'h8000_7FFF, 32'h0000_8000, 32'h0B0A_0908);
        run_op("R4", 32'h7FFF_8000, 32'hFFFF_7FFF, 32'h0B0A_0908);
        // R2: mixed codes across lanes
        run_op("R2", 32'hDEAD_BEEF, 32'h0123_4567, 32'h0C0D_0B03);
        run_op("R2", 32'hCAFE_F00D, 32'h89AB_CDEF, 32'hFF0C_0907);
        // R6: high codes with upper bits that must not wrap
        run_op("R6", 32'h1122_3344, 32'h5566_7788, 32'h8088_8C10);

        // Sweep all codes through each lane, other lanes random
        for (int lane = 0; lane < 4; lane++) begin
            for (int c = 0; c < 256; c++) begin
                logic [31:0] s;
                s = $urandom;
                s[lane*8 +: 8] = 8'(c);
                run_op(tag_of(c), $urandom, $urandom, s);
            end
        end

        // Random operands with codes biased toward the interesting range
        for (int n = 0; n < 1500; n++) begin
            logic [31:0] s;
            for (int i = 0; i < 4; i++)
                s[i*8 +: 8] = ($urandom_range(0, 3) != 0) ? 8'($urandom_range(0, 15)) : 8'($urandom);
            run_op("R2", $urandom, $urandom, s);
        end

        // R8: idle edge with changed inputs keeps the result
        run_op("R8 setup", 32'hA5A5_0F0F, 32'h3C3C_9696, 32'h0501_0C0E);
        last = result;
        @(negedge clk);
        in_valid = 1'b0; hi_word = 32'hFFFF_FFFF; lo_word = 32'h1234_5678; sel_word = 32'h0001_0203;
        @(negedge clk);
        check("R8 valid low", {31'd0, out_valid}, 32'd0);
        check("R8 result held", result, last);

        // R9: reset while a transfer is offered
        run_op("R9 setup", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0706_0504);
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        check("R9 valid cleared", {31'd0, out_valid}, 32'd0);
        check("R9 result cleared", result, 32'd0);
        rst_n = 1'b1; in_valid = 1'b0;
        run_op("R7 after reset", 32'h0BAD_F00D, 32'h600D_CAFE, 32'h0004_0D08);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule